// File: doc/BRIEF.md
# Supply Switchover Time Stamp

This block records the calendar time at the moments a device moves between its main supply and its backup battery. An external comparator supplies a level that is high while the device runs from the battery. The block resynchronises that level, detects each change, and copies the present seconds, minutes, hours, date and month into one of two stamp banks. A software-visible clear command wipes both banks.

The two banks follow different policies. The power-down bank records the change from main supply to battery. It keeps the first such event and ignores later power-downs until it is cleared. The power-up bank records the change from battery back to main supply, and every new return overwrites it. Each bank has a valid flag, and its fields read as zero while the flag is low.

Top module: `supply_stamp`

## Requirements
- R1: After reset both valid flags are 0 and every stamp field reads 0.
- R2: The battery-mode input passes through two synchroniser flops before edge detection. A change applied between clock edges changes the stamps at the third rising clock edge after the change, and not before.
- R3: A 0-to-1 change of the battery-mode input loads the present time fields into the power-down bank and sets its valid flag, provided that flag was 0.
- R4: While the power-down valid flag is 1 and no clear is applied, later 0-to-1 changes leave that bank unchanged.
- R5: A 1-to-0 change of the battery-mode input always loads the present time fields into the power-up bank and sets its valid flag, replacing any earlier stamp.
- R6: A clear command sampled high sets both valid flags to 0 and all stamp fields to 0.
- R7: When a clear and a capture fall on the same clock edge, the capturing bank ends holding the new stamp with its valid flag set. This holds even if the power-down bank was already valid. The other bank is cleared.
- R8: Changes to the time fields with no battery-mode change leave both banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bat_mode_in | input | 1 | Asynchronous level, 1 while running from battery |
| clr_stamp | input | 1 | Clear both stamp banks |
| t_sec | input | SEC_W | Present seconds |
| t_min | input | MIN_W | Present minutes |
| t_hour | input | HOUR_W | Present hours |
| t_date | input | DATE_W | Present day of month |
| t_month | input | MON_W | Present month |
| dn_valid | output | 1 | Power-down stamp holds an event |
| dn_sec | output | SEC_W | Power-down seconds |
| dn_min | output | MIN_W | Power-down minutes |
| dn_hour | output | HOUR_W | Power-down hours |
| dn_date | output | DATE_W | Power-down date |
| dn_month | output | MON_W | Power-down month |
| up_valid | output | 1 | Power-up stamp holds an event |
| up_sec | output | SEC_W | Power-up seconds |
| up_min | output | MIN_W | Power-up minutes |
| up_hour | output | HOUR_W | Power-up hours |
| up_date | output | DATE_W | Power-up date |
| up_month | output | MON_W | Power-up month |

## Verification
The bench repeats power-downs while the power-down bank is already valid. A design that overwrote on every edge would then show the later time instead of the first one. It lines a clear up with the capture edge, and there a design that let clear win would lose the event and read an empty bank. It also checks the stamps one cycle before the expected capture, which catches a synchroniser chain that is one flop short. Random time changes made without any mode change catch a bank that tracks the live time instead of latching it.

// File: rtl/supply_stamp.sv
module supply_stamp #(
  parameter int SEC_W  = 7,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DATE_W = 6,
  parameter int MON_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bat_mode_in,
  input  logic              clr_stamp,
  input  logic [SEC_W-1:0]  t_sec,
  input  logic [MIN_W-1:0]  t_min,
  input  logic [HOUR_W-1:0] t_hour,
  input  logic [DATE_W-1:0] t_date,
  input  logic [MON_W-1:0]  t_month,
  output logic              dn_valid,
  output logic [SEC_W-1:0]  dn_sec,
  output logic [MIN_W-1:0]  dn_min,
  output logic [HOUR_W-1:0] dn_hour,
  output logic [DATE_W-1:0] dn_date,
  output logic [MON_W-1:0]  dn_month,
  output logic              up_valid,
  output logic [SEC_W-1:0]  up_sec,
  output logic [MIN_W-1:0]  up_min,
  output logic [HOUR_W-1:0] up_hour,
  output logic [DATE_W-1:0] up_date,
  output logic [MON_W-1:0]  up_month
);
  localparam int STAMP_W = SEC_W + MIN_W + HOUR_W + DATE_W + MON_W;
  localparam int O_MIN   = SEC_W;
  localparam int O_HOUR  = O_MIN + MIN_W;
  localparam int O_DATE  = O_HOUR + HOUR_W;
  localparam int O_MON   = O_DATE + DATE_W;

  logic [2:0]         bat_sr;
  logic               to_bat, to_main;
  logic [STAMP_W-1:0] now, dn_q, up_q;
  logic               dn_v, up_v;

  always_ff @(posedge clk) begin
    if (!rst_n) bat_sr <= '0;
    else        bat_sr <= {bat_sr[1:0], bat_mode_in};
  end

  assign to_bat  =  bat_sr[1] & ~bat_sr[2];
  assign to_main = ~bat_sr[1] &  bat_sr[2];
  assign now     = {t_month, t_date, t_hour, t_min, t_sec};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_v <= 1'b0;
      dn_q <= '0;
    end else if (to_bat && (!dn_v || clr_stamp)) begin
      dn_v <= 1'b1;
      dn_q <= now;
    end else if (clr_stamp) begin
      dn_v <= 1'b0;
      dn_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_v <= 1'b0;
      up_q <= '0;
    end else if (to_main) begin
      up_v <= 1'b1;
      up_q <= now;
    end else if (clr_stamp) begin
      up_v <= 1'b0;
      up_q <= '0;
    end
  end

  assign dn_valid = dn_v;
  assign dn_sec   = dn_q[SEC_W-1:0];
  assign dn_min   = dn_q[O_HOUR-1:O_MIN];
  assign dn_hour  = dn_q[O_DATE-1:O_HOUR];
  assign dn_date  = dn_q[O_MON-1:O_DATE];
  assign dn_month = dn_q[STAMP_W-1:O_MON];

  assign up_valid = up_v;
  assign up_sec   = up_q[SEC_W-1:0];
  assign up_min   = up_q[O_HOUR-1:O_MIN];
  assign up_hour  = up_q[O_DATE-1:O_HOUR];
  assign up_date  = up_q[O_MON-1:O_DATE];
  assign up_month = up_q[STAMP_W-1:O_MON];
endmodule

module supply_stamp_chk #(
  parameter int W = 31
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic [W-1:0] now,
  input logic         dn_v,
  input logic [W-1:0] dn_q,
  input logic         up_v,
  input logic [W-1:0] up_q
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !dn_v && !up_v && dn_q == '0 && up_q == '0);
  p_dn_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_v) |-> dn_q == $past(now));
  p_dn_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dn_v && !clr |=> dn_v && $stable(dn_q));
  p_up_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    up_v && !$stable(up_q) |-> up_q == $past(now));
  p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_v -> dn_q == '0) && (!up_v -> up_q == '0));
endmodule

bind supply_stamp supply_stamp_chk #(.W(STAMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr_stamp), .now(now),
  .dn_v(dn_v), .dn_q(dn_q), .up_v(up_v), .up_q(up_q)
);

// File: tb/tb_supply_stamp.sv
`timescale 1ns/1ps
module tb_supply_stamp;
  localparam int W = 31;

  logic clk = 0, rst_n = 0, bat = 0, clr = 0;
  logic [W-1:0] now_tb = '0;
  logic dn_valid, up_valid;
  logic [6:0] dn_sec, dn_min, up_sec, up_min;
  logic [5:0] dn_hour, dn_date, up_hour, up_date;
  logic [4:0] dn_month, up_month;
  int total = 0, bad = 0;
  logic ev_dn, ev_up;
  logic [W-1:0] e_dn, e_up;

  always #2 clk = ~clk;

  supply_stamp dut (
    .clk(clk), .rst_n(rst_n), .bat_mode_in(bat), .clr_stamp(clr),
    .t_sec(now_tb[6:0]), .t_min(now_tb[13:7]), .t_hour(now_tb[19:14]),
    .t_date(now_tb[25:20]), .t_month(now_tb[30:26]),
    .dn_valid(dn_valid), .dn_sec(dn_sec), .dn_min(dn_min), .dn_hour(dn_hour),
    .dn_date(dn_date), .dn_month(dn_month),
    .up_valid(up_valid), .up_sec(up_sec), .up_min(up_min), .up_hour(up_hour),
    .up_date(up_date), .up_month(up_month)
  );

  function automatic logic [W:0] pack_dn();
    return {dn_valid, dn_month, dn_date, dn_hour, dn_min, dn_sec};
  endfunction
  function automatic logic [W:0] pack_up();
    return {up_valid, up_month, up_date, up_hour, up_min, up_sec};
  endfunction

  task automatic check(string req, logic [W:0] got, logic [W:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_both(string rd, string ru);
    check(rd, pack_dn(), {ev_dn, e_dn});
    check(ru, pack_up(), {ev_up, e_up});
  endtask

  function automatic void model_clear();
    ev_dn = 0; e_dn = '0; ev_up = 0; e_up = '0;
  endfunction

  function automatic void model_edge(logic lvl);
    if (lvl) begin
      if (!ev_dn) begin ev_dn = 1; e_dn = now_tb; end
    end else begin
      ev_up = 1; e_up = now_tb;
    end
  endfunction

  // op 0: mode toggle, 1: clear, 2: toggle with clear on capture edge, 3: time only
  task automatic step(int op);
    @(negedge clk);
    now_tb = W'($urandom);
    case (op)
      0: begin
        bat = ~bat;
        repeat (2) @(negedge clk);
        check_both("R2 dn early", "R2 up early");
        @(negedge clk);
        model_edge(bat);
        check_both(bat ? "R3/R4 dn" : "R5 dn", bat ? "R3 up" : "R5 up");
      end
      1: begin
        clr = 1;
        @(negedge clk);
        clr = 0;
        model_clear();
        repeat (2) @(negedge clk);
        check_both("R6 dn", "R6 up");
      end
      2: begin
        bat = ~bat;
        repeat (2) @(negedge clk);
        check_both("R2 dn early", "R2 up early");
        clr = 1;
        @(negedge clk);
        clr = 0;
        model_clear();
        model_edge(bat);
        check_both("R7 dn", "R7 up");
      end
      default: begin
        repeat (3) @(negedge clk);
        now_tb = W'($urandom);
        @(negedge clk);
        check_both("R8 dn", "R8 up");
      end
    endcase
  endtask

  logic finished = 0;

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog got=hang exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_both("R1 dn", "R1 up");
    step(0);  // R3 first power-down
    step(0);  // R5 first return
    step(0);  // R4 second power-down ignored
    step(0);  // R5 overwrite
    step(3);  // R8
    step(1);  // R6
    step(0);
    step(0);
    step(2);  // R7 capture wins with bank valid
    step(2);
    for (int i = 0; i < 300; i++) step(int'($urandom % 4));
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule